// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block produces the refresh traffic for a DDR memory controller. A programmable interval timer creates refresh requests, and so does a test control bit. The requests wait in a pending counter that holds up to eight of them. The block drains that counter when the controller reports an idle slot. It stops waiting for an idle slot once the counter is full.

One refresh cycle sends a refresh command to every module bank. A programmable stagger spaces the commands to successive banks by 0 to 16 clocks. A stagger of zero sends one command that covers all banks in the same clock.

The command leaves on a valid/ready stream. A per-bank strobe vector is the valid side and `cmd_ready` is the ready side. Once a strobe vector is presented it stays unchanged until `cmd_ready` is sampled high. The consumer may hold `cmd_ready` low for any number of clocks. The scheduler keeps collecting requests during that time and does not advance to the next bank.

Top module: `ref_sched_top`

## Requirements
- R1: While `cfg_interval` holds a nonzero value k and is unchanged, one request is generated every 16·k clocks. The first request comes 16·k clocks after the value was last changed.
- R2: When `cfg_interval` is zero, no periodic request is generated. Requests already pending are kept.
- R3: A rising edge on `test_req` adds exactly one request. Holding `test_req` high adds nothing more.
- R4: The pending count saturates at 8. A test edge and a periodic request arriving in the same clock add two requests, still limited to 8.
- R5: With 1 to 7 requests pending and no cycle in progress, a refresh cycle starts only in a clock where `ctrl_idle` is high. Its first command appears on the next clock. With no requests pending, no cycle starts.
- R6: With 8 requests pending and no cycle in progress, a cycle starts regardless of `ctrl_idle`. `urgent` is high exactly while 8 requests are pending.
- R7: With a latched stagger of 0, a refresh cycle is one command with every bit of `ref_cmd` set.
- R8: With a latched stagger s of 1 to 16, banks are commanded one at a time in order 0 to NBANK-1. Each bank's strobe (bit i of `ref_cmd` for bank i) appears s clocks after the clock in which the previous bank was accepted. Values above 16 act as 16. The stagger is latched when the cycle starts.
- R9: A presented `ref_cmd` holds steady until accepted (`cmd_ready` high in the same clock). Acceptance of the final command of a cycle removes one pending request.
- R10: Any change of `cfg_interval` restarts the interval timer from zero.
- R11: After reset, `ref_cmd` is zero, `urgent` is low, and no requests are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | IVL_W | Refresh interval in units of 16 clocks; 0 disables the timer |
| cfg_stagger | input | 5 | Clocks between per-bank commands; 0 means all banks together, values above 16 act as 16 |
| test_req | input | 1 | Test control bit; each rising edge adds one request |
| ctrl_idle | input | 1 | Controller has an idle slot for an opportunistic refresh |
| ref_cmd | output | NBANK | Per-bank refresh command strobes (valid side of the stream) |
| cmd_ready | input | 1 | Command accepted in this clock (ready side of the stream) |
| urgent | output | 1 | Pending count is at its limit of 8 |

## Verification
The assertions assume the consumer is free to drive `cmd_ready` in any pattern. They also assume `cfg_stagger`, `ctrl_idle` and `test_req` may change in any clock. The only property the checks build on is that a cycle never completes with an empty count. The scheduler guarantees that itself, because a cycle starts only when the count is nonzero.

The stimulus changes configuration and control inputs only at the falling edge. It includes a pseudo-random `cmd_ready` pattern, so back-pressure arrives both in the middle of a staggered cycle and at its end. Test-bit edges are timed to collide with timer requests while the count is at or near the limit.

// File: rtl/ref_pkg.sv
package ref_pkg;
  localparam int STAG_W   = 5;
  localparam int STAG_MAX = 16;

  typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_state_t;

  function automatic logic [STAG_W-1:0] clamp_stag(input logic [STAG_W-1:0] raw);
    return (raw > STAG_W'(STAG_MAX)) ? STAG_W'(STAG_MAX) : raw;
  endfunction
endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] ivl,
  output logic             tick
);
  localparam int CNT_W = IVL_W + 4;

  logic [IVL_W-1:0] ivl_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_val;
  logic             changed;

  assign last_val = {ivl, 4'b0000} - CNT_W'(1);
  assign changed  = (ivl != ivl_q);
  assign tick     = !changed && (ivl != '0) && (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt   <= '0;
    end else begin
      ivl_q <= ivl;
      if (changed || ivl == '0 || tick) cnt <= '0;
      else                              cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ref_req_queue.sv
module ref_req_queue #(
  parameter int DEPTH = 8,
  localparam int QCW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           test_req,
  input  logic           done,
  output logic [QCW-1:0] qcnt,
  output logic           full,
  output logic           empty
);
  localparam int SW = QCW + 2;

  logic          test_q;
  logic          tpulse;
  logic [SW-1:0] sum;

  assign tpulse = test_req & ~test_q;
  assign full   = (qcnt == QCW'(DEPTH));
  assign empty  = (qcnt == '0);

  always_comb begin
    sum = {2'b00, qcnt} + SW'(tick) + SW'(tpulse) - SW'(done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= 1'b0;
      qcnt   <= '0;
    end else begin
      test_q <= test_req;
      if (sum > SW'(DEPTH)) qcnt <= QCW'(DEPTH);
      else                  qcnt <= sum[QCW-1:0];
    end
  end
endmodule

// File: rtl/ref_bank_seq.sv
module ref_bank_seq
  import ref_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [STAG_W-1:0] cfg_stagger,
  input  logic              cmd_ready,
  output logic [NBANK-1:0]  ref_cmd,
  output logic              done,
  output logic              busy
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  seq_state_t        state;
  logic [BW-1:0]     bank;
  logic [STAG_W-1:0] wcnt;
  logic [STAG_W-1:0] stag_q;
  logic              cmd_on;
  logic              accept;
  logic              last;

  assign busy   = (state == SEQ_BUSY);
  assign cmd_on = busy && (wcnt == '0);
  assign accept = cmd_on && cmd_ready;
  assign last   = (stag_q == '0) || (bank == BW'(NBANK - 1));
  assign done   = accept && last;

  for (genvar g = 0; g < NBANK; g++) begin : g_strobe
    assign ref_cmd[g] = cmd_on && ((stag_q == '0) || (bank == BW'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      bank   <= '0;
      wcnt   <= '0;
      stag_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_ok) begin
            state  <= SEQ_BUSY;
            bank   <= '0;
            wcnt   <= '0;
            stag_q <= clamp_stag(cfg_stagger);
          end
        end
        default: begin
          if (accept) begin
            if (last) begin
              state <= SEQ_IDLE;
            end else begin
              bank <= bank + BW'(1);
              wcnt <= stag_q - STAG_W'(1);
            end
          end else if (wcnt != '0) begin
            wcnt <= wcnt - STAG_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ref_sched_top.sv
module ref_sched_top
  import ref_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int IVL_W   = 16,
  parameter int Q_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic [STAG_W-1:0] cfg_stagger,
  input  logic              test_req,
  input  logic              ctrl_idle,
  output logic [NBANK-1:0]  ref_cmd,
  input  logic              cmd_ready,
  output logic              urgent
);
  localparam int QCW = $clog2(Q_DEPTH + 1);

  logic           tick;
  logic [QCW-1:0] qcnt;
  logic           q_full;
  logic           q_empty;
  logic           seq_done;
  logic           seq_busy;
  logic           start_ok;

  assign start_ok = !q_empty && (ctrl_idle || q_full);
  assign urgent   = q_full;

  ref_tick_gen #(.IVL_W(IVL_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .ivl  (cfg_interval),
    .tick (tick)
  );

  ref_req_queue #(.DEPTH(Q_DEPTH)) u_queue (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .test_req(test_req),
    .done    (seq_done),
    .qcnt    (qcnt),
    .full    (q_full),
    .empty   (q_empty)
  );

  ref_bank_seq #(.NBANK(NBANK)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_ok   (start_ok),
    .cfg_stagger(cfg_stagger),
    .cmd_ready  (cmd_ready),
    .ref_cmd    (ref_cmd),
    .done       (seq_done),
    .busy       (seq_busy)
  );
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int NBANK   = 4,
  parameter int IVL_W   = 16,
  parameter int Q_DEPTH = 8,
  localparam int QCW    = $clog2(Q_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IVL_W-1:0] cfg_interval,
  input logic             ctrl_idle,
  input logic             cmd_ready,
  input logic [NBANK-1:0] ref_cmd,
  input logic             urgent,
  input logic             tick,
  input logic [QCW-1:0]   qcnt,
  input logic             seq_busy,
  input logic             seq_done
);
  AST_TIMER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_interval == '0) |-> !tick);                                   // R2
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= QCW'(Q_DEPTH));                                            // R4
  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !urgent && !ctrl_idle) |=> !seq_busy);               // R5
  AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && qcnt == '0) |=> !seq_busy);                          // R5
  AST_FORCED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !seq_busy) |=> seq_busy);                               // R6
  AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ref_cmd) || (&ref_cmd));                                  // R8
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ref_cmd) && !cmd_ready) |=> ref_cmd == $past(ref_cmd));         // R9
  AST_DONE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> qcnt != '0);                                          // R9
endmodule

bind ref_sched_top ref_sched_chk #(
  .NBANK(NBANK), .IVL_W(IVL_W), .Q_DEPTH(Q_DEPTH)
) u_chk (.*);

// File: tb/sim_ref_sched_top.sv
`timescale 1ns/1ps
module sim_ref_sched_top;
  localparam int NB = 4;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] cfg_interval = '0;
  logic [4:0]    cfg_stagger = 5'd0;
  logic          test_req = 1'b0;
  logic          ctrl_idle = 1'b0;
  logic          cmd_ready = 1'b1;
  logic [NB-1:0] ref_cmd;
  logic          urgent;

  int    vectors = 0;
  int    fails = 0;
  bit    finished = 0;
  string phase = "R11";
  bit    rand_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  ref_sched_top #(.NBANK(NB), .IVL_W(IW), .Q_DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
    .cfg_stagger(cfg_stagger), .test_req(test_req), .ctrl_idle(ctrl_idle),
    .ref_cmd(ref_cmd), .cmd_ready(cmd_ready), .urgent(urgent)
  );

  // Behavioural reference: absolute cycle numbers decide when a strobe is due.
  int m_cyc, m_prev_ivl, m_timer, m_q, m_bank, m_due, m_stag;
  bit m_busy, m_tprev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_prev_ivl = 0; m_timer = 0; m_q = 0;
      m_bank = 0; m_due = 0; m_stag = 0; m_busy = 0; m_tprev = 0;
    end else begin
      bit showing, taken, finish, gen, pulse, go;
      int iv;
      iv      = int'(cfg_interval);
      showing = m_busy && (m_cyc >= m_due);
      taken   = showing && cmd_ready;
      finish  = taken && (m_stag == 0 || m_bank == NB - 1);
      gen = 0;
      if (iv != m_prev_ivl || iv == 0) m_timer = 0;
      else if (m_timer == 16 * iv - 1) begin gen = 1; m_timer = 0; end
      else m_timer++;
      m_prev_ivl = iv;
      pulse   = test_req && !m_tprev;
      m_tprev = test_req;
      go = !m_busy && m_q > 0 && (ctrl_idle || m_q == 8);
      m_q = m_q - int'(finish) + int'(gen) + int'(pulse);
      if (m_q > 8) m_q = 8;
      if (finish) m_busy = 0;
      else if (taken) begin m_bank++; m_due = m_cyc + m_stag; end
      if (go) begin
        m_busy = 1; m_bank = 0; m_due = m_cyc + 1;
        m_stag = (int'(cfg_stagger) > 16) ? 16 : int'(cfg_stagger);
      end
      m_cyc++;
    end
  end

  always @(negedge clk) begin
    logic [NB-1:0] e_cmd;
    logic e_urg;
    e_cmd = '0;
    if (m_busy && m_cyc >= m_due) e_cmd = (m_stag == 0) ? '1 : NB'(1) << m_bank;
    e_urg = (m_q == 8);
    if (!finished) begin
      vectors++;
      if (ref_cmd !== e_cmd || urgent !== e_urg) begin
        fails++;
        $display("FAIL %s t=%0t ref_cmd=%b exp=%b urgent=%b exp=%b",
                 phase, $time, ref_cmd, e_cmd, urgent, e_urg);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cmd_ready = rand_ready ? lfsr[3] : 1'b1;
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_test(int hold, int gap);
    test_req = 1'b1; run(hold);
    test_req = 1'b0; run(gap);
  endtask

  initial begin
    run(4);                                  // R11: reset state compared every clock
    rst_n = 1'b1;
    run(4);
    phase = "R1"; ctrl_idle = 1; cfg_stagger = 0; cfg_interval = 16'd2;
    run(200);
    phase = "R10"; cfg_interval = 16'd5; run(30);
    cfg_interval = 16'd3; run(150);
    phase = "R2"; ctrl_idle = 0; cfg_interval = 16'd0; run(10);
    phase = "R3";
    for (int i = 0; i < 3; i++) pulse_test(1, 3);
    pulse_test(30, 5);                       // held high: one request only
    phase = "R2"; run(100);                  // pending kept, no timer requests
    phase = "R6"; cfg_stagger = 5'd2;
    for (int i = 0; i < 4; i++) pulse_test(2, 2);
    run(80);
    phase = "R4"; cfg_interval = 16'd1; rand_ready = 1;
    for (int i = 0; i < 40; i++) pulse_test(1, 7);
    phase = "R5";
    for (int i = 0; i < 300; i++) begin ctrl_idle = lfsr[7] & lfsr[2]; run(1); end
    ctrl_idle = 1;
    phase = "R7"; cfg_stagger = 5'd0; run(200);
    phase = "R8"; rand_ready = 0; cfg_stagger = 5'd3; run(250);
    cfg_stagger = 5'd20; run(300);
    cfg_stagger = 5'd16; rand_ready = 1; run(300);
    phase = "R9"; cfg_stagger = 5'd1;
    for (int i = 0; i < 10; i++) pulse_test(1, 20);
    run(200);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog phase %s: run did not end, expected completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule